// File: doc/BRIEF.md
# Timed PCM Sample Streamer

This block plays raw sample bytes out of CPU-visible memory at a steady pace. Software sets a start address and a sample count, then turns playback on. From then on a rate counter marks one sample slot every `RATE` clock cycles. In each slot the block fetches one byte through a request/valid memory port. It drops the byte's lowest bit and writes the upper seven bits to a DAC register.

When the count runs out, the next slot stops playback, sets a flag and raises an interrupt. Software clears the flag by writing the control register again. The three sample registers respond only while a mode bit is set. That bit is held in a fourth register. While it is clear, the block leaves the surrounding register space to other logic. The read port shows the interrupt flag at the control offset.

Top module: `pcm_dma_top`

## Requirements
- R1: After reset `irq_o`, `mem_req_o` and `dac_we_o` are 0, and a read at offset 0x15 returns 0x00.
- R2: A write to offset 0x30 stores bit 4 of the data as the mode bit. Writes to offsets 0x12, 0x13 and 0x15 have no effect while the mode bit is 0.
- R3: A write to offset 0x12 sets the start address to the data times 64. The first fetch after it uses that address.
- R4: A write to offset 0x15 with bit 4 set enables playback and restarts the rate counter. The first fetch request appears `RATE` cycles after the write edge, and later slots follow every `RATE` cycles.
- R5: One cycle after the cycle in which `mem_valid_i` is accepted, `dac_we_o` pulses for one cycle and `dac_data_o` holds the fetched byte shifted right by one.
- R6: Each completed fetch advances the address by one, wrapping within 15 bits.
- R7: A write to offset 0x13 sets the remaining count to data*16+1. In a slot where the count is nonzero, one sample is fetched and the count drops by one. In a slot where it is already zero, no fetch is made: playback stops and `irq_o` rises at that slot's edge.
- R8: Any write to offset 0x15 in mode clears the interrupt flag. Bit 4 of that write set to 0 disables playback, so no further fetches occur.
- R9: A read at offset 0x15 returns {flag, 7'b0} while the mode bit is 1. A read there returns 0x00 while the mode bit is 0, and `irq_o` still follows the flag.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one CPU cycle per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write offset |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 6 | Register read offset |
| rd_data_o | output | 8 | Status readback |
| mem_req_o | output | 1 | Sample fetch request |
| mem_addr_o | output | 15 | Sample fetch address |
| mem_valid_i | input | 1 | Fetch data valid |
| mem_data_i | input | 8 | Fetched sample byte |
| dac_we_o | output | 1 | DAC write pulse |
| dac_data_o | output | 7 | DAC sample value |
| irq_o | output | 1 | End-of-sample interrupt |

## Verification
A register write takes effect at the edge that samples it. The bench therefore records the cycle number of that edge and measures every later result from it.

The fetch request appears `RATE` edges after the enable write. With a memory that answers on the first cycle, the DAC pulse is seen one edge later. The flag rises exactly at the slot after the last sample, so for a count of one it is due `2*RATE` edges after the enable. The bench samples at the falling edge. It checks the flag one cycle before and on the due cycle, and it logs every DAC pulse with its cycle number so that spacing and order can be compared with the computed values.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;
  localparam int unsigned REG_AW = 6;
  localparam logic [REG_AW-1:0] OFS_START = 6'h12;
  localparam logic [REG_AW-1:0] OFS_LEN   = 6'h13;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h15;
  localparam logic [REG_AW-1:0] OFS_MODE  = 6'h30;
  localparam int unsigned MODE_BIT  = 4;
  localparam int unsigned EN_BIT    = 4;
  localparam int unsigned ADDR_SHIFT = 6;
  localparam int unsigned LEN_SHIFT  = 4;
endpackage

// File: rtl/pcm_rate_timer.sv
module pcm_rate_timer #(
  parameter int unsigned RATE = 246,
  localparam int unsigned CW = $clog2(RATE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q <= CW'(1));
  assign tick_o = run_i && last && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= CW'(RATE);
    else if (load_i)            cnt_q <= CW'(RATE);
    else if (run_i && last)     cnt_q <= CW'(RATE);
    else if (run_i)             cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/pcm_fetch.sv
module pcm_fetch #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_val_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          dac_we_o,
  output logic [DW-2:0] dac_data_o
);
  logic          busy_q, we_q;
  logic [AW-1:0] addr_q, req_addr_q;
  logic [DW-1:0] data_q;
  logic          done;

  assign done       = busy_q && mem_valid_i;
  assign mem_req_o  = busy_q;
  assign mem_addr_o = req_addr_q;
  assign dac_we_o   = we_q;
  assign dac_data_o = (DW-1)'(data_q >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      we_q       <= 1'b0;
      req_addr_q <= '0;
      data_q     <= '0;
    end else begin
      we_q <= done;
      if (done) begin
        busy_q <= 1'b0;
        data_q <= mem_data_i;
      end else if (start_i && !busy_q) begin
        busy_q     <= 1'b1;
        req_addr_q <= addr_q;
      end
    end
  end

  // address pointer: register load wins over post-fetch increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_q <= '0;
    else if (addr_load_i) addr_q <= addr_val_i;
    else if (done)        addr_q <= addr_q + AW'(1);
  end
endmodule

// File: rtl/pcm_dma_top.sv
module pcm_dma_top
  import pcm_dma_pkg::*;
#(
  parameter int unsigned RATE   = 246,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LEN_W = DATA_W + LEN_SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              dac_we_o,
  output logic [DATA_W-2:0] dac_data_o,
  output logic              irq_o
);
  logic             mode_q, en_q, irq_q;
  logic [LEN_W-1:0] remain_q;
  logic             act, start_wr, len_wr, ctrl_wr, tick, slot, fetch_go;

  assign act      = wr_en_i && mode_q;
  assign start_wr = act && (wr_addr_i == OFS_START);
  assign len_wr   = act && (wr_addr_i == OFS_LEN);
  assign ctrl_wr  = act && (wr_addr_i == OFS_CTRL);
  assign slot     = tick && !ctrl_wr;
  assign fetch_go = slot && (remain_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  mode_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == OFS_MODE)    mode_q <= wr_data_i[MODE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      irq_q    <= 1'b0;
      remain_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= wr_data_i[EN_BIT];
        irq_q <= 1'b0;
      end else if (slot && remain_q == '0) begin
        en_q  <= 1'b0;
        irq_q <= 1'b1;
      end
      if (len_wr)        remain_q <= (LEN_W'(wr_data_i) << LEN_SHIFT) + LEN_W'(1);
      else if (fetch_go) remain_q <= remain_q - LEN_W'(1);
    end
  end

  pcm_rate_timer #(.RATE(RATE)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q),
    .load_i (ctrl_wr && wr_data_i[EN_BIT]),
    .tick_o (tick)
  );

  pcm_fetch #(.AW(ADDR_W), .DW(DATA_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (fetch_go),
    .addr_load_i (start_wr),
    .addr_val_i  (ADDR_W'(wr_data_i) << ADDR_SHIFT),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_data_i  (mem_data_i),
    .dac_we_o    (dac_we_o),
    .dac_data_o  (dac_data_o)
  );

  assign irq_o     = irq_q;
  assign rd_data_o = (mode_q && rd_addr_i == OFS_CTRL) ? {irq_q, (DATA_W-1)'(0)} : '0;
endmodule

// File: rtl/pcm_dma_chk.sv
module pcm_dma_chk
  import pcm_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              dac_we_o,
  input logic              irq_o,
  input logic              mode_q,
  input logic              en_q
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R5
  dac_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_we_o) |-> $past(mem_req_o && mem_valid_i));

  // R2
  gated_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !mode_q && wr_addr_i == OFS_CTRL |=> $stable(en_q) && $stable(irq_o));

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && mode_q && wr_addr_i == OFS_CTRL |=> !irq_o);

  // R7
  irq_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !en_q);

  // R9
  status_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-2:0] == '0);
endmodule

bind pcm_dma_top pcm_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .rd_data_o   (rd_data_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .dac_we_o    (dac_we_o),
  .irq_o       (irq_o),
  .mode_q      (mode_q),
  .en_q        (en_q)
);

// File: tb/sim_pcm_dma_top.sv
`timescale 1ns/1ps
module sim_pcm_dma_top;
  localparam int RATE = 246;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = 6'h15;
  logic [7:0]  wr_data = '0, rd_data, mem_data = '0;
  logic        mem_req, mem_valid = 1'b0, dac_we, irq;
  logic [14:0] mem_addr;
  logic [6:0]  dac_data;

  int cyc = 0, n_chk = 0, n_err = 0, mw = 0;
  int dac_n = 0, req_n = 0, hold_err = 0, t0 = 0;
  int dac_cyc [32];
  logic [6:0]  dac_log [32];
  logic [14:0] req_log [32];
  logic        req_prev = 1'b0;
  logic [14:0] addr_prev = '0;

  pcm_dma_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_data_i(mem_data), .dac_we_o(dac_we), .dac_data_o(dac_data), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(input logic [14:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // memory model: even addresses answer at once, odd ones two cycles later
  always @(negedge clk) begin
    if (!mem_req) begin mw = 0; mem_valid = 1'b0; end
    else if (mem_valid) mem_valid = 1'b0;
    else if (mw == (mem_addr[0] ? 2 : 0)) begin
      mem_valid = 1'b1; mem_data = mem_byte(mem_addr); mw = 0;
    end else mw++;
  end

  always @(negedge clk) begin
    if (dac_we && dac_n < 32) begin
      dac_log[dac_n] = dac_data; dac_cyc[dac_n] = cyc;
    end
    if (dac_we) dac_n++;
    if (mem_req && !req_prev && req_n < 32) req_log[req_n] = mem_addr;
    if (mem_req && !req_prev) req_n++;
    if (mem_req && req_prev && mem_addr != addr_prev) hold_err++;
    req_prev = mem_req; addr_prev = mem_addr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; t0 = cyc;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(irq == 0 && mem_req == 0 && dac_we == 0, "R1 outputs", {irq, mem_req, dac_we}, 0);
    chk(rd_data == 8'h00, "R1 status", rd_data, 0);
  endtask

  task automatic t_gated;
    int n0;
    n0 = dac_n;
    wr(6'h12, 8'h10); wr(6'h13, 8'h00); wr(6'h15, 8'h10);
    wait_to(t0 + 2 * RATE + 10);
    chk(dac_n == n0 && req_n == 0, "R2 no playback out of mode", dac_n, n0);
    chk(rd_data == 8'h00, "R9 status out of mode", rd_data, 0);
    wr(6'h30, 8'h10);
    chk(rd_data == 8'h00, "R9 status flag clear", rd_data, 0);
  endtask

  task automatic t_stream;
    int bad_a, bad_d;
    bad_a = 0; bad_d = 0;
    wr(6'h12, 8'h05); wr(6'h13, 8'h01); wr(6'h15, 8'h10);
    wait_to(t0 + 18 * RATE + 5);
    chk(dac_n == 17, "R7 sample count", dac_n, 17);
    chk(req_log[0] == 15'h0140, "R3 start address", req_log[0], 'h140);
    chk(dac_cyc[0] == t0 + RATE + 1, "R4 first slot", dac_cyc[0], t0 + RATE + 1);
    chk(dac_cyc[2] - dac_cyc[0] == 2 * RATE, "R4 slot spacing", dac_cyc[2] - dac_cyc[0], 2 * RATE);
    for (int k = 0; k < 17; k++) begin
      if (req_log[k] != 15'(15'h0140 + k)) bad_a++;
      if (dac_log[k] != mem_byte(15'(15'h0140 + k)) >> 1) bad_d++;
    end
    chk(bad_a == 0, "R6 address advance", bad_a, 0);
    chk(bad_d == 0, "R5 DAC data", bad_d, 0);
    chk(hold_err == 0, "R10 request hold", hold_err, 0);
    chk(irq == 1, "R7 irq raised", irq, 1);
    chk(rd_data == 8'h80, "R9 status flag", rd_data, 'h80);
    wait_to(cyc + 2 * RATE);
    chk(dac_n == 17 && req_n == 17, "R7 stopped", dac_n, 17);
  endtask

  task automatic t_irq_timing;
    int n0;
    n0 = dac_n;
    wr(6'h13, 8'h00); wr(6'h15, 8'h10);
    chk(irq == 0, "R8 flag cleared by enable write", irq, 0);
    wait_to(t0 + 2 * RATE - 1);
    chk(irq == 0 && dac_n == n0 + 1, "R7 irq not early", irq, 0);
    wait_to(t0 + 2 * RATE);
    chk(irq == 1, "R7 irq on slot", irq, 1);
  endtask

  task automatic t_clear;
    int n0;
    wr(6'h12, 8'h02); wr(6'h13, 8'h03); wr(6'h15, 8'h10);
    wait_to(t0 + RATE + 5);
    wr(6'h15, 8'h00);
    n0 = dac_n;
    chk(irq == 0 && rd_data == 8'h00, "R8 flag cleared", rd_data, 0);
    wait_to(t0 + 3 * RATE);
    chk(dac_n == n0, "R8 disabled", dac_n, n0);
  endtask

  task automatic t_mode_off;
    wr(6'h13, 8'h00); wr(6'h15, 8'h10);
    wait_to(t0 + 2 * RATE + 2);
    wr(6'h30, 8'h00);
    chk(rd_data == 8'h00, "R9 status hidden", rd_data, 0);
    wr(6'h15, 8'h00);
    chk(irq == 1, "R2 clear ignored out of mode", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gated();
    t_stream();
    t_irq_timing();
    t_clear();
    t_mode_off();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule